// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block is the receive buffer of a 16550-style serial controller. The receive shifter writes bytes into it, and reads of the receive-buffer register take them out. In FIFO mode it holds up to 16 bytes. In non-FIFO mode it holds a single byte.

Around the storage the block does five things:
- It raises a trigger-reached flag at a programmable fill level.
- It records overruns.
- It inserts a zero byte when a line break is received.
- It carries out the clear actions of the FIFO control register.
- It runs a character-timeout timer whose length follows the current frame format.

The bit period comes from an external baud divider as a one-cycle `baud_tick` pulse. The frame format comes in as `frame_cfg`. The block supplies the fill count, data-ready, overrun and break status, the trigger flag and the timeout-pending flag. It also supplies a one-cycle pulse that asks the transmit side to clear its own FIFO.

Top module: `rx_fifo_trig_tmo`

## Requirements
- R1: After reset the block is in non-FIFO mode, and `rx_count`, `data_ready`, `overrun`, `brk_ind`, `trig_hit` and `tmo_pend` are all 0.
- R2: In FIFO mode (control bit 0 = 1), bytes are read out in arrival order and `rx_count` gives the fill level. A read of an empty FIFO returns 0x00.
- R3: A byte that arrives while 16 bytes are held is discarded, the held bytes are kept, and `overrun` is set. A status read (`st_rd`) clears `overrun` and `brk_ind`.
- R4: Control bits 7:6 select the trigger level:
  - code 00 selects 1 byte;
  - code 01 selects 4 bytes;
  - code 10 selects 8 bytes;
  - code 11 selects 14 bytes.

  In FIFO mode `trig_hit` is 1 when `rx_count` is at or above the selected level. In non-FIFO mode `trig_hit` equals `data_ready`.
- R5: A control write with bit 1 set empties the receive FIFO and clears `tmo_pend`. A control write with bit 2 set pulses `tx_clr`. A write that changes bit 0 does both clears.
- R6: Only control bits 7, 6, 3 and 0 are stored (mask 0xC9). A control write whose value equals the stored value has no effect, even if bits 1 or 2 are set.
- R7: The timeout restarts at four character times on each arrival in FIFO mode. It also restarts on each read that leaves the FIFO non-empty. When it expires with data held, `tmo_pend` is set. Any read clears `tmo_pend`.
- R8: One character time is a number of `baud_tick` pulses equal to the frame length. The frame length is the sum of:
  - 1 start bit;
  - 5 + `frame_cfg[1:0]` data bits;
  - 1 parity bit if `frame_cfg[3]` is set;
  - 2 stop bits if `frame_cfg[2]` is set, otherwise 1.
- R9: The read that empties the FIFO clears `data_ready` and `brk_ind`.
- R10: A received break (`rx_break`) stores a 0x00 byte and sets `brk_ind` and `data_ready`.
- R11: In non-FIFO mode, a byte that arrives while `data_ready` is 1 replaces the held byte and sets `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the FIFO control register |
| ctl_wdata | input | 8 | Value written to the FIFO control register |
| frame_cfg | input | 4 | Frame format: [1:0] data length code, [2] two stop bits, [3] parity |
| baud_tick | input | 1 | One pulse per bit period |
| rx_valid | input | 1 | Shifter delivers a byte |
| rx_data | input | 8 | Byte delivered by the shifter |
| rx_break | input | 1 | Line break detected |
| rd_en | input | 1 | Read of the receive-buffer register |
| rd_data | output | 8 | Byte returned by the current read |
| st_rd | input | 1 | Read of line status; clears overrun and break |
| rx_count | output | 5 | Bytes held |
| data_ready | output | 1 | At least one byte held |
| overrun | output | 1 | Overrun status |
| brk_ind | output | 1 | Break status |
| trig_hit | output | 1 | Fill level at or above the trigger |
| tmo_pend | output | 1 | Character timeout pending |
| fifo_on | output | 1 | FIFO mode active |
| tx_clr | output | 1 | One-cycle request to clear the transmit FIFO |

## Verification
The assertions take four things for granted:
- A read, a status read, a control write and an arrival never fall in the same cycle. The properties about one of these actions exclude the others in their antecedents.
- `rx_valid` and `rx_break` are never raised together.
- `frame_cfg` is steady while a timeout is running.
- `baud_tick` lasts one cycle.

The stimulus drives each action in its own cycle, on the falling clock edge. It changes `frame_cfg` only after the FIFO has been cleared, and it pulses `baud_tick` alone so that the bench counts ticks exactly.

// File: rtl/rx_fifo_trig_tmo.sv
module rx_fifo_trig_tmo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int MAXF  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic [3:0]    frame_cfg,
  input  logic          baud_tick,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          st_rd,
  output logic [$clog2(DEPTH):0] rx_count,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_ind,
  output logic          trig_hit,
  output logic          tmo_pend,
  output logic          fifo_on,
  output logic          tx_clr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = $clog2(4 * MAXF + 1);

  logic [7:0]    fcr_q;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx, lvl;
  logic [DW-1:0] hold;
  logic          hold_v;
  logic [TW-1:0] tmr;
  logic          run;
  logic [3:0]    frame_len;

  wire ctl_go  = ctl_wr && (ctl_wdata != fcr_q);
  wire en_flip = ctl_go && (ctl_wdata[0] ^ fcr_q[0]);
  wire rx_clr  = ctl_go && (ctl_wdata[1] || en_flip);
  assign tx_clr  = ctl_go && (ctl_wdata[2] || en_flip);
  assign fifo_on = fcr_q[0];

  wire full     = (cnt == CW'(DEPTH));
  wire empty    = (cnt == '0);
  wire push_req = rx_valid || rx_break;
  wire [DW-1:0] push_byte = rx_break ? '0 : rx_data;
  wire push_ok  = fifo_on && push_req && !full;
  wire pop      = fifo_on && rd_en && !empty;
  assign cnt_nx = cnt + CW'(push_ok) - CW'(pop);

  wire ovr_set = fifo_on ? (push_req && full)
                         : (rx_valid && !rx_break && hold_v && !rd_en);
  wire drained = fifo_on ? (pop && cnt_nx == '0) : (rd_en && !push_req);

  assign frame_len = 4'd7 + {2'b00, frame_cfg[1:0]} + {3'b000, frame_cfg[3]}
                   + {3'b000, frame_cfg[2]};
  wire [TW-1:0] tmo_load = TW'({frame_len, 2'b00});
  wire restart = fifo_on && (push_req || (pop && cnt_nx != '0));
  wire expire  = run && baud_tick && (tmr == TW'(1)) && !restart && !drained;

  always_comb begin
    case (fcr_q[7:6])
      2'b00:   lvl = CW'(1);
      2'b01:   lvl = CW'(4);
      2'b10:   lvl = CW'(8);
      default: lvl = CW'(14);
    endcase
  end

  assign rd_data    = fifo_on ? (empty ? '0 : mem[rp]) : hold;
  assign rx_count   = fifo_on ? cnt : CW'(hold_v);
  assign data_ready = fifo_on ? !empty : hold_v;
  assign trig_hit   = fifo_on ? (cnt >= lvl) : hold_v;

  always_ff @(posedge clk) begin
    if (push_ok && !rx_clr) mem[wp] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q <= '0;
      wp <= '0; rp <= '0; cnt <= '0;
      hold <= '0; hold_v <= 1'b0;
      overrun <= 1'b0; brk_ind <= 1'b0;
      tmr <= '0; run <= 1'b0; tmo_pend <= 1'b0;
    end else begin
      if (ctl_go) fcr_q <= ctl_wdata & 8'hC9;
      if (ovr_set) overrun <= 1'b1;
      else if (st_rd) overrun <= 1'b0;
      if (rx_clr) begin
        wp <= '0; rp <= '0; cnt <= '0;
        hold_v <= 1'b0; brk_ind <= 1'b0;
        run <= 1'b0; tmo_pend <= 1'b0;
      end else begin
        if (fifo_on) begin
          if (push_ok) wp <= wp + 1'b1;
          if (pop)     rp <= rp + 1'b1;
          cnt <= cnt_nx;
        end else if (push_req) begin
          hold <= push_byte; hold_v <= 1'b1;
        end else if (rd_en) begin
          hold_v <= 1'b0;
        end
        if (rx_break) brk_ind <= 1'b1;
        else if (st_rd || drained) brk_ind <= 1'b0;
        if (restart) begin
          tmr <= tmo_load; run <= 1'b1;
        end else if (drained) begin
          run <= 1'b0;
        end else if (run && baud_tick) begin
          tmr <= tmr - 1'b1;
          if (tmr == TW'(1)) run <= 1'b0;
        end
        if (rd_en) tmo_pend <= 1'b0;
        else if (expire && !empty) tmo_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) p_count_bound_r2: assert (cnt <= CW'(DEPTH));
  end

  p_keep_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && full && rx_valid && !rd_en && !ctl_wr) |=> (overrun && rx_count == CW'(DEPTH)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_count == '0 && !tmo_pend));

  p_equal_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == fcr_q && !push_req && !rd_en) |=> ($stable(rx_count) && !$past(tx_clr)));

  p_read_clears_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !tmo_pend);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && rd_en && cnt == CW'(1) && !push_req && !ctl_wr) |=> (!data_ready && !brk_ind));

  p_break_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && rx_break && !full && !rd_en && !ctl_wr && !st_rd) |=>
    (brk_ind && data_ready && rx_count == $past(cnt) + CW'(1)));

  p_nf_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && hold_v && rx_valid && !rx_break && !rd_en && !ctl_wr) |=> (overrun && data_ready));
endmodule

// File: tb/rx_fifo_trig_tmo_tb_top.sv
module rx_fifo_trig_tmo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, baud_tick = 0, rx_valid = 0, rx_break = 0, rd_en = 0, st_rd = 0;
  logic [7:0] ctl_wdata = 0, rx_data = 0, rd_data;
  logic [3:0] frame_cfg = 0;
  logic [4:0] rx_count;
  logic data_ready, overrun, brk_ind, trig_hit, tmo_pend, fifo_on, tx_clr;
  int n_chk = 0, n_fail = 0;
  logic [7:0] d;

  localparam logic [9:0] TMO_VEC [4] = '{ {4'h0, 6'd28}, {4'h3, 6'd40}, {4'hF, 6'd48}, {4'h9, 6'd36} };
  localparam int LVL [4] = '{1, 4, 8, 14};

  always #10 clk = ~clk;

  rx_fifo_trig_tmo dut_i (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .frame_cfg, .baud_tick, .rx_valid, .rx_data,
    .rx_break, .rd_en, .rd_data, .st_rd, .rx_count, .data_ready, .overrun, .brk_ind,
    .trig_hit, .tmo_pend, .fifo_on, .tx_clr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_en = 1; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wctl(input logic [7:0] v, output logic txp);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v; #1 txp = tx_clr;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic srd();
    @(negedge clk); st_rd = 1;
    @(negedge clk); st_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baud_tick = 1;
      @(negedge clk); baud_tick = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", rx_count, 0);
    chk("R1 flags", {data_ready, overrun, brk_ind, trig_hit, tmo_pend, fifo_on}, 0);

    wctl(8'h01, t);
    chk("R5 enable flips tx_clr", t, 1);
    chk("R6 fifo_on", fifo_on, 1);
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk("R2 count", rx_count, 3);
    rd(d); chk("R2 order0", d, 8'hA1);
    rd(d); chk("R2 order1", d, 8'hB2);
    rd(d); chk("R2 order2", d, 8'hC3);
    chk("R9 dr cleared", data_ready, 0);
    rd(d); chk("R2 empty read", d, 8'h00);

    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    chk("R3 full count", rx_count, 16);
    chk("R3 no overrun yet", overrun, 0);
    push(8'hEE);
    chk("R3 count kept", rx_count, 16);
    chk("R3 overrun", overrun, 1);
    rd(d); chk("R3 head kept", d, 8'h10);
    for (int i = 1; i < 15; i++) rd(d);
    rd(d); chk("R3 tail kept", d, 8'h1F);
    chk("R3 still overrun", overrun, 1);
    srd();
    chk("R3 status read clears", overrun, 0);

    for (int c = 0; c < 4; c++) begin
      wctl({2'(c), 6'b000011}, t);
      for (int k = 0; k < LVL[c] - 1; k++) push(8'(k));
      chk($sformatf("R4 below level code %0d", c), trig_hit, 0);
      push(8'h77);
      chk($sformatf("R4 at level code %0d", c), trig_hit, 1);
    end

    wctl(8'hC1, t);
    push(8'h01); push(8'h02);
    wctl(8'hC1, t);
    chk("R6 equal write ignored", rx_count, 4'd14 + 5'd2);
    wctl(8'hF1, t);
    chk("R6 masked bits no clear", rx_count, 16);
    chk("R6 masked bits no tx_clr", t, 0);
    wctl(8'hC5, t);
    chk("R5 tx_clr pulse", t, 1);
    chk("R5 bit2 keeps rx", rx_count, 16);
    wctl(8'hC3, t);
    chk("R5 rx cleared", rx_count, 0);

    frame_cfg = 4'h0;
    push(8'h42);
    ticks(28);
    chk("R7 pend before clear", tmo_pend, 1);
    wctl(8'hC3, t);
    chk("R5 clear drops pend", tmo_pend, 0);
    chk("R5 clear count", rx_count, 0);

    for (int v = 0; v < 4; v++) begin
      wctl(8'h03, t);
      frame_cfg = TMO_VEC[v][9:6];
      push(8'h5A);
      ticks(int'(TMO_VEC[v][5:0]) - 1);
      chk($sformatf("R8 no expiry cfg %0h", frame_cfg), tmo_pend, 0);
      ticks(1);
      chk($sformatf("R8 expiry cfg %0h", frame_cfg), tmo_pend, 1);
      rd(d);
      chk("R7 read clears pend", tmo_pend, 0);
    end

    wctl(8'h03, t);
    frame_cfg = 4'h0;
    push(8'h61); push(8'h62);
    ticks(27);
    rd(d);
    ticks(27);
    chk("R7 restart on read", tmo_pend, 0);
    ticks(1);
    chk("R7 expiry after restart", tmo_pend, 1);
    rd(d); chk("R7 second byte", d, 8'h62);
    ticks(30);
    chk("R7 empty no pend", tmo_pend, 0);

    brk();
    chk("R10 break count", rx_count, 1);
    chk("R10 break flags", {brk_ind, data_ready}, 2'b11);
    rd(d); chk("R10 break byte", d, 8'h00);
    chk("R9 emptying read clears", {brk_ind, data_ready}, 2'b00);
    brk(); srd();
    chk("R3 status read clears break", brk_ind, 0);

    push(8'h33);
    wctl(8'h00, t);
    chk("R5 disable clears tx", t, 1);
    chk("R5 disable clears rx", rx_count, 0);
    chk("R6 fifo off", fifo_on, 0);
    push(8'h55);
    chk("R11 holding ready", data_ready, 1);
    chk("R4 nf trig follows dr", trig_hit, 1);
    push(8'h66);
    chk("R11 overrun", overrun, 1);
    rd(d); chk("R11 overwritten byte", d, 8'h66);
    chk("R11 dr cleared", data_ready, 0);
    chk("R4 nf trig low", trig_hit, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule